// File: doc/BRIEF.md
# Byte-Register I2C Master Controller

This block is an I2C bus master that software drives through six 8-bit registers on a simple single-byte read/write port. Software programs a clock divider and sets the enable, master and direction bits in the control register. From then on the data register drives each bus transaction. The first data write after the cycle is reset becomes a START followed by a 7-bit slave address, with the read/write flag in bit 0. Later data writes are sent as payload bytes. When the direction bit selects receive, each read of the data register returns the byte already held and starts fetching the next one.

The status register reports the outcome. Bit 7 means a byte completed, bit 5 means the bus is busy, bit 1 is the interrupt flag and bit 0 means a NACK was received. One interrupt line is high when the block is enabled, interrupts are enabled and the interrupt flag is set. Clearing the master bit ends the transfer with a STOP. Setting the repeated-start bit during a cycle makes the next data write an address phase that begins with a repeated START. Clearing the enable bit while the block is enabled performs a soft reset that keeps only the own-address register.

The SCL and SDA lines are open-drain. Each has a pull-low enable output and a line-level input. The bit engine takes four divider ticks per bit. A tick occurs every (divider + 2) clocks. The engine holds the high phase of SCL while a target stretches the clock.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the registers read as follows: own address 0x00, divider 0x00, control 0x00, status 0x81, data 0x00 and filter 0x00. The interrupt output is low and neither line is pulled low.
- R2: The register offsets are 0x00 own address, 0x04 divider, 0x08 control, 0x0C status, 0x10 data and 0x14 filter. Writes are masked with 0xFE for own address, 0x3F for divider, 0xFC for control and 0xED for status. The filter register keeps all 8 bits, and any other offset reads 0.
- R3: Writing control with bit 5 (master) set sets status bit 5. Writing control with bit 5 clear clears status bit 5, and if a cycle is active the block drives a STOP on the bus.
- R4: A data write made while control bit 7 (enable) is clear has no effect. The data register keeps its previous value.
- R5: In master mode with no active cycle, a data write sends START and then the byte MSB first. If the address is acknowledged, status bit 0 is cleared, bits 7 and 1 are set, and the cycle becomes active.
- R6: If the address is not acknowledged, status bit 0 is set and bit 7 stays clear. The cycle stays inactive, so the next data write is again an address phase.
- R7: While a cycle is active, a data write sends the byte MSB first. An acknowledged byte clears status bit 0 and sets bits 7 and 1.
- R8: A NACK on a payload byte sets status bit 0, leaves bit 7 clear, ends the cycle and drives a STOP.
- R9: A data-register read returns the held value. In master mode with control bit 4 clear and a cycle active, the read also fetches the next byte. The fetched byte is acknowledged unless control bit 3 is set, and on completion status bits 7 and 1 are set.
- R10: A data-register read in master receive mode with no active cycle loads 0xFF into the data register and causes no bus activity.
- R11: Setting control bit 2 during an active cycle ends the cycle and bit 2 reads back as 0. The next data write is an address phase that uses a repeated START, with no STOP in between.
- R12: Writing control with bit 7 clear while the block is enabled returns every register except the own address to its reset value. The rest of that write is discarded and both lines are released.
- R13: The interrupt output equals control bit 7 AND control bit 6 AND status bit 1. Writing status with bit 1 clear lowers it.
- R14: Status bit 7 reads 0 while an address, payload or receive byte is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_sel is high |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Pull SCL low |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | SDA line level |

## Verification
The assertions assume that software never writes status bit 7 as 1 while an address, payload or receive byte is on the bus. They also assume the line inputs are clean, already-synchronous copies of the open-drain wires. The stimulus writes the status register only when the engine is idle or holding the bus between bytes. The target model changes SDA only on a falling SCL edge, and the lines are formed as wired-AND of the master and the target. The target acknowledges only its own address and NACKs the payload byte 0xEE, which lets the bench reach the address-NACK and data-NACK paths on purpose.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  localparam int OFS_OWN = 'h00;
  localparam int OFS_DIV = 'h04;
  localparam int OFS_CTL = 'h08;
  localparam int OFS_STA = 'h0C;
  localparam int OFS_DAT = 'h10;
  localparam int OFS_FLT = 'h14;

  localparam int CTL_EN   = 7;
  localparam int CTL_IE   = 6;
  localparam int CTL_MST  = 5;
  localparam int CTL_TX   = 4;
  localparam int CTL_NAK  = 3;
  localparam int CTL_RS   = 2;

  localparam int STA_DONE = 7;
  localparam int STA_BUSY = 5;
  localparam int STA_FLAG = 1;
  localparam int STA_NAK  = 0;

  localparam logic [7:0] OWN_MASK = 8'hFE;
  localparam logic [7:0] DIV_MASK = 8'h3F;
  localparam logic [7:0] CTL_MASK = 8'hFC;
  localparam logic [7:0] STA_MASK = 8'hED;
  localparam logic [7:0] STA_RST  = 8'h81;
  localparam logic [7:0] NO_TGT   = 8'hFF;

  typedef enum logic [1:0] {
    CMD_ADDR = 2'd0,
    CMD_TX   = 2'd1,
    CMD_RX   = 2'd2,
    CMD_STOP = 2'd3
  } cmd_e;
endpackage

// File: rtl/i2c_bm_prescale.sv
module i2c_bm_prescale #(
  parameter int DIV_W   = 6,
  parameter int MIN_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 2;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;
  logic             tick_d, tick_q;

  assign limit = CNT_W'(div) + CNT_W'(MIN_DIV - 1);

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (!en) begin
      cnt_d = '0;
    end else if (cnt_q >= limit) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/i2c_bm_engine.sv
module i2c_bm_engine
  import i2c_bm_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            abort,
  input  logic            cmd_valid,
  input  cmd_e            cmd_kind,
  input  logic [BITS-1:0] cmd_byte,
  input  logic            cmd_txak,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            ready,
  output logic            busy,
  output logic            done,
  output logic            ack,
  output logic [BITS-1:0] rx_data,
  output logic            scl_low,
  output logic            sda_low
);
  localparam int BIT_W = $clog2(BITS + 1);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(BITS);

  typedef enum logic [2:0] {
    E_IDLE, E_START, E_RSTART, E_BIT, E_HOLD, E_STOP
  } est_e;

  est_e             st_q, st_d;
  logic [1:0]       q_q, q_d;
  logic [BIT_W-1:0] b_q, b_d;
  logic [BITS-1:0]  sh_q, sh_d;
  cmd_e             kind_q, kind_d;
  logic             txak_q, txak_d;
  logic             ack_q, ack_d;
  logic             scl_q, scl_d;
  logic             sda_q, sda_d;
  logic             done_q, done_d;

  assign ready = (st_q == E_IDLE) || (st_q == E_HOLD);

  always_comb begin
    st_d   = st_q;
    q_d    = q_q;
    b_d    = b_q;
    sh_d   = sh_q;
    kind_d = kind_q;
    txak_d = txak_q;
    ack_d  = ack_q;
    scl_d  = scl_q;
    sda_d  = sda_q;
    done_d = 1'b0;
    if (abort) begin
      st_d  = E_IDLE;
      q_d   = '0;
      scl_d = 1'b0;
      sda_d = 1'b0;
    end else if (ready && cmd_valid) begin
      kind_d = cmd_kind;
      sh_d   = cmd_byte;
      txak_d = cmd_txak;
      q_d    = '0;
      b_d    = '0;
      case (cmd_kind)
        CMD_STOP: st_d = (st_q == E_HOLD) ? E_STOP : E_IDLE;
        CMD_ADDR: st_d = (st_q == E_HOLD) ? E_RSTART : E_START;
        default:  st_d = (st_q == E_HOLD) ? E_BIT : E_START;
      endcase
    end else if (tick) begin
      case (st_q)
        E_START: begin
          if (q_q == 2'd0) sda_d = 1'b1;
          if (q_q == 2'd2) scl_d = 1'b1;
          q_d = q_q + 2'd1;
          if (q_q == 2'd3) begin
            st_d = E_BIT;
            b_d  = '0;
          end
        end
        E_RSTART: begin
          case (q_q)
            2'd0: sda_d = 1'b0;
            2'd1: scl_d = 1'b0;
            2'd2: sda_d = 1'b1;
            default: begin
              scl_d = 1'b1;
              st_d  = E_BIT;
              b_d   = '0;
            end
          endcase
          q_d = q_q + 2'd1;
        end
        E_STOP: begin
          case (q_q)
            2'd0: sda_d = 1'b1;
            2'd1: scl_d = 1'b0;
            2'd2: sda_d = 1'b0;
            default: st_d = E_IDLE;
          endcase
          q_d = q_q + 2'd1;
        end
        E_BIT: begin
          case (q_q)
            2'd0: begin
              if (b_q < LAST)
                sda_d = (kind_q == CMD_RX) ? 1'b0 : ~sh_q[BITS-1];
              else
                sda_d = (kind_q == CMD_RX) ? ~txak_q : 1'b0;
              q_d = 2'd1;
            end
            2'd1: begin
              scl_d = 1'b0;
              q_d   = 2'd2;
            end
            2'd2: begin
              if (scl_in) begin
                if (b_q < LAST) begin
                  if (kind_q == CMD_RX) sh_d = {sh_q[BITS-2:0], sda_in};
                end else begin
                  ack_d = ~sda_in;
                end
                q_d = 2'd3;
              end
            end
            default: begin
              scl_d = 1'b1;
              q_d   = 2'd0;
              if (b_q == LAST) begin
                st_d   = E_HOLD;
                done_d = 1'b1;
              end else begin
                b_d = b_q + 1'b1;
                if (kind_q != CMD_RX) sh_d = {sh_q[BITS-2:0], 1'b0};
              end
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      q_q    <= '0;
      b_q    <= '0;
      sh_q   <= '0;
      kind_q <= CMD_TX;
      txak_q <= 1'b0;
      ack_q  <= 1'b0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      q_q    <= q_d;
      b_q    <= b_d;
      sh_q   <= sh_d;
      kind_q <= kind_d;
      txak_q <= txak_d;
      ack_q  <= ack_d;
      scl_q  <= scl_d;
      sda_q  <= sda_d;
      done_q <= done_d;
    end
  end

  assign busy    = ~ready;
  assign done    = done_q;
  assign ack     = ack_q;
  assign rx_data = sh_q;
  assign scl_low = scl_q;
  assign sda_low = sda_q;
endmodule

// File: rtl/i2c_bm_regs.sv
module i2c_bm_regs
  import i2c_bm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DIV_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              irq,
  input  logic              eng_ready,
  input  logic              eng_done,
  input  logic              eng_ack,
  input  logic [7:0]        eng_rx,
  output logic              cmd_valid,
  output cmd_e              cmd_kind,
  output logic [7:0]        cmd_byte,
  output logic              cmd_txak,
  output logic              eng_abort,
  output logic [DIV_W-1:0]  div,
  output logic              en,
  output logic [7:0]        cr_o,
  output logic [7:0]        sr_o,
  output logic [7:0]        tgt_o,
  output cmd_e              op_o
);
  localparam logic [ADDR_W-1:0] A_OWN = ADDR_W'(OFS_OWN);
  localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'(OFS_DIV);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
  localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(OFS_STA);
  localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(OFS_DAT);
  localparam logic [ADDR_W-1:0] A_FLT = ADDR_W'(OFS_FLT);

  logic [7:0] own_q, own_d, div_q, div_d, cr_q, cr_d, sr_q, sr_d;
  logic [7:0] dr_q, dr_d, flt_q, flt_d, tgt_q, tgt_d;
  logic       stop_q, stop_d;
  cmd_e       op_q, op_d;
  logic [7:0] cr_n;
  logic       wr, rd;

  assign wr = sel && we;
  assign rd = sel && !we;

  always_comb begin
    own_d = own_q; div_d = div_q; cr_d = cr_q; sr_d = sr_q;
    dr_d = dr_q; flt_d = flt_q; tgt_d = tgt_q; stop_d = stop_q; op_d = op_q;
    cmd_valid = 1'b0;
    cmd_kind  = CMD_TX;
    cmd_byte  = dr_q;
    eng_abort = 1'b0;
    cr_n      = '0;

    if (eng_done) begin
      case (op_q)
        CMD_ADDR: begin
          if (eng_ack) begin
            tgt_d = dr_q;
            sr_d[STA_NAK]  = 1'b0;
            sr_d[STA_DONE] = 1'b1;
            sr_d[STA_FLAG] = 1'b1;
          end else begin
            sr_d[STA_NAK] = 1'b1;
          end
        end
        CMD_TX: begin
          if (eng_ack) begin
            sr_d[STA_NAK]  = 1'b0;
            sr_d[STA_DONE] = 1'b1;
            sr_d[STA_FLAG] = 1'b1;
          end else begin
            sr_d[STA_NAK] = 1'b1;
            tgt_d  = NO_TGT;
            stop_d = 1'b1;
          end
        end
        CMD_RX: begin
          dr_d = eng_rx;
          sr_d[STA_DONE] = 1'b1;
          sr_d[STA_FLAG] = 1'b1;
        end
        default: ;
      endcase
    end

    if (wr) begin
      if (addr == A_OWN) own_d = wdata & OWN_MASK;
      if (addr == A_DIV) div_d = wdata & DIV_MASK;
      if (addr == A_STA) sr_d  = wdata & STA_MASK;
      if (addr == A_FLT) flt_d = wdata;
      if (addr == A_CTL) begin
        if (cr_q[CTL_EN] && !wdata[CTL_EN]) begin
          div_d = '0; cr_d = '0; sr_d = STA_RST; dr_d = '0; flt_d = '0;
          tgt_d = NO_TGT; stop_d = 1'b0; op_d = CMD_TX;
          eng_abort = 1'b1;
        end else begin
          cr_n = wdata & CTL_MASK;
          if (cr_n[CTL_MST]) begin
            sr_d[STA_BUSY] = 1'b1;
          end else begin
            sr_d[STA_BUSY] = 1'b0;
            if (tgt_d != NO_TGT) begin
              stop_d = 1'b1;
              tgt_d  = NO_TGT;
            end
          end
          if (cr_n[CTL_RS] && (tgt_d != NO_TGT)) begin
            tgt_d        = NO_TGT;
            cr_n[CTL_RS] = 1'b0;
          end
          cr_d = cr_n;
        end
      end
      if ((addr == A_DAT) && cr_q[CTL_EN] && eng_ready && !stop_q) begin
        dr_d = wdata;
        if (cr_q[CTL_MST]) begin
          cmd_valid = 1'b1;
          cmd_kind  = (tgt_d == NO_TGT) ? CMD_ADDR : CMD_TX;
          cmd_byte  = wdata;
          op_d      = cmd_kind;
          sr_d[STA_DONE] = 1'b0;
        end
      end
    end

    if (rd && (addr == A_DAT) && cr_q[CTL_MST] && !cr_q[CTL_TX]) begin
      if (tgt_d == NO_TGT) begin
        dr_d = NO_TGT;
      end else if (eng_ready && !stop_q) begin
        cmd_valid = 1'b1;
        cmd_kind  = CMD_RX;
        op_d      = CMD_RX;
        sr_d[STA_DONE] = 1'b0;
      end
    end

    if (!cmd_valid && !eng_abort && stop_q && eng_ready) begin
      cmd_valid = 1'b1;
      cmd_kind  = CMD_STOP;
      op_d      = CMD_STOP;
      stop_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= '0; div_q <= '0; cr_q <= '0; sr_q <= STA_RST;
      dr_q <= '0; flt_q <= '0; tgt_q <= NO_TGT; stop_q <= 1'b0; op_q <= CMD_TX;
    end else begin
      own_q <= own_d; div_q <= div_d; cr_q <= cr_d; sr_q <= sr_d;
      dr_q <= dr_d; flt_q <= flt_d; tgt_q <= tgt_d; stop_q <= stop_d; op_q <= op_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_OWN) rdata = own_q;
    if (addr == A_DIV) rdata = div_q;
    if (addr == A_CTL) rdata = cr_q;
    if (addr == A_STA) rdata = sr_q;
    if (addr == A_DAT) rdata = dr_q;
    if (addr == A_FLT) rdata = flt_q;
  end

  assign irq      = cr_q[CTL_EN] & cr_q[CTL_IE] & sr_q[STA_FLAG];
  assign cmd_txak = cr_q[CTL_NAK];
  assign div      = div_q[DIV_W-1:0];
  assign en       = cr_q[CTL_EN];
  assign cr_o     = cr_q;
  assign sr_o     = sr_q;
  assign tgt_o    = tgt_q;
  assign op_o     = op_q;
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DIV_W   = 6,
  parameter int MIN_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic              scl_oe,
  input  logic              scl_in,
  output logic              sda_oe,
  input  logic              sda_in
);
  logic             tick, en, eng_abort;
  logic             eng_ready, eng_busy, eng_done, eng_ack;
  logic [7:0]       eng_rx, cmd_byte;
  logic             cmd_valid, cmd_txak;
  cmd_e             cmd_kind;
  logic [DIV_W-1:0] div;
  logic [7:0]       cr_w, sr_w, tgt_w;
  cmd_e             op_w;

  i2c_bm_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .irq(irq),
    .eng_ready(eng_ready), .eng_done(eng_done), .eng_ack(eng_ack), .eng_rx(eng_rx),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_byte(cmd_byte), .cmd_txak(cmd_txak),
    .eng_abort(eng_abort), .div(div), .en(en),
    .cr_o(cr_w), .sr_o(sr_w), .tgt_o(tgt_w), .op_o(op_w)
  );

  i2c_bm_prescale #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en), .div(div), .tick(tick)
  );

  i2c_bm_engine #(.BITS(8)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .abort(eng_abort),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_byte(cmd_byte), .cmd_txak(cmd_txak),
    .scl_in(scl_in), .sda_in(sda_in), .ready(eng_ready), .busy(eng_busy),
    .done(eng_done), .ack(eng_ack), .rx_data(eng_rx),
    .scl_low(scl_oe), .sda_low(sda_oe)
  );
endmodule

// File: rtl/i2c_bm_chk.sv
module i2c_bm_chk
  import i2c_bm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cr,
  input logic [7:0] sr,
  input logic [7:0] tgt,
  input cmd_e       op,
  input logic       eng_busy,
  input logic       eng_done,
  input logic       eng_ack,
  input logic       irq,
  input logic       scl_oe,
  input logic       sda_oe
);
  // R13
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cr[7] && sr[1]));

  // R14
  done_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && op != CMD_STOP) |-> !sr[7]);

  // R5
  target_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tgt) == 8'hFF && tgt != 8'hFF) |-> ($past(eng_done) && $past(eng_ack)));

  // R12
  off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cr[7] |-> (!scl_oe && !sda_oe));

  // R8
  nack_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eng_done && !eng_ack && op == CMD_TX) |-> tgt == 8'hFF);
endmodule

bind i2c_byte_master i2c_bm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cr(cr_w), .sr(sr_w), .tgt(tgt_w), .op(op_w),
  .eng_busy(eng_busy), .eng_done(eng_done), .eng_ack(eng_ack),
  .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/test_i2c_byte_master.sv
module test_i2c_byte_master;
  localparam int PERIOD = 10;
  localparam logic [6:0] SLV = 7'h3A;

  logic clk, rst_n, bus_sel, bus_we, irq, scl_oe, sda_oe;
  logic [4:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic s_drive;
  wire scl_w = !scl_oe;
  wire sda_w = !(sda_oe || s_drive);

  int checks, fails;
  bit finished;

  i2c_byte_master i_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .scl_oe(scl_oe), .scl_in(scl_w), .sda_oe(sda_oe), .sda_in(sda_w)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // target model
  int s_state, s_bit, s_hits, s_stops;
  bit s_skip, s_match, s_rw, s_mack;
  logic [7:0] s_shift, s_last_rx, s_txb;
  initial begin
    s_state = 0; s_bit = 0; s_hits = 0; s_stops = 0; s_drive = 1'b0;
    s_skip = 0; s_match = 0; s_rw = 0; s_mack = 0; s_shift = 0; s_last_rx = 0; s_txb = 0;
  end
  always @(negedge sda_w) if (scl_w === 1'b1) begin
    s_state = 1; s_bit = 0; s_drive = 1'b0; s_skip = 1;
  end
  always @(posedge sda_w) if (scl_w === 1'b1) begin
    if (s_state != 0) s_stops++;
    s_state = 0; s_drive = 1'b0;
  end
  always @(posedge scl_w) begin
    if ((s_state == 1 || s_state == 2) && s_bit < 8) s_shift = {s_shift[6:0], sda_w};
    if (s_state == 3 && s_bit == 8) s_mack = !sda_w;
  end
  always @(negedge scl_w) begin
    if (s_skip) s_skip = 0;
    else case (s_state)
      1, 2: begin
        if (s_bit == 7) begin
          s_bit = 8;
          if (s_state == 1) begin
            s_match = (s_shift[7:1] == SLV); s_rw = s_shift[0]; s_drive = s_match;
            if (s_match) s_hits++;
          end else begin
            s_last_rx = s_shift; s_drive = (s_shift != 8'hEE);
          end
        end else if (s_bit == 8) begin
          s_bit = 0; s_drive = 1'b0;
          if (s_state == 1) begin
            if (!s_match) s_state = 4;
            else if (s_rw) begin s_state = 3; s_txb = 8'hA5; s_drive = !s_txb[7]; end
            else s_state = 2;
          end else if (s_last_rx == 8'hEE) s_state = 4;
        end else s_bit++;
      end
      3: begin
        if (s_bit == 8) begin
          s_bit = 0;
          if (s_mack) begin s_txb++; s_drive = !s_txb[7]; end
          else begin s_state = 4; s_drive = 1'b0; end
        end else if (s_bit == 7) begin
          s_bit = 8; s_drive = 1'b0;
        end else begin
          s_bit++; s_drive = !s_txb[7 - s_bit];
        end
      end
      default: s_drive = 1'b0;
    endcase
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #(PERIOD/4);
    d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rdchk("R1 own", 5'h00, 8'h00); rdchk("R1 div", 5'h04, 8'h00);
    rdchk("R1 ctl", 5'h08, 8'h00); rdchk("R1 sta", 5'h0C, 8'h81);
    rdchk("R1 dat", 5'h10, 8'h00); rdchk("R1 flt", 5'h14, 8'h00);
    check("R1 irq", irq, 0); check("R1 lines", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_masks;
    wr(5'h00, 8'hFF); rdchk("R2 own mask", 5'h00, 8'hFE);
    wr(5'h04, 8'hFF); rdchk("R2 div mask", 5'h04, 8'h3F);
    wr(5'h14, 8'h5A); rdchk("R2 filter", 5'h14, 8'h5A);
    wr(5'h08, 8'h5F); rdchk("R2 ctl mask", 5'h08, 8'h5C);
    wr(5'h08, 8'h00);
    wr(5'h0C, 8'hFF); rdchk("R2 sta mask", 5'h0C, 8'hED);
    rdchk("R2 unmapped", 5'h18, 8'h00);
    check("R13 irq needs enable", irq, 0);
  endtask

  task automatic t_disabled;
    wr(5'h10, 8'h77); rdchk("R4 data ignored", 5'h10, 8'h00);
    wait_clk(20); check("R4 no bus", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_addr_ack;
    wr(5'h04, 8'h02); wr(5'h0C, 8'h80);
    wr(5'h08, 8'hB0); rdchk("R3 busy set", 5'h0C, 8'hA0);
    wr(5'h10, 8'h74); rdchk("R14 done clear in flight", 5'h0C, 8'h20);
    wait_clk(300);
    rdchk("R5 addr ack status", 5'h0C, 8'hA2);
    check("R5 target hit", s_hits, 1);
  endtask

  task automatic t_tx;
    wr(5'h0C, 8'h20); wr(5'h10, 8'hC3); wait_clk(300);
    check("R7 byte received", s_last_rx, 8'hC3);
    rdchk("R7 status", 5'h0C, 8'hA2);
  endtask

  task automatic t_irq;
    wr(5'h08, 8'hF0); wait_clk(2); check("R13 irq high", irq, 1);
    wr(5'h0C, 8'h20); wait_clk(2); check("R13 irq cleared", irq, 0);
  endtask

  task automatic t_tx_nack;
    wr(5'h10, 8'hEE); wait_clk(300);
    rdchk("R8 nack status", 5'h0C, 8'h21);
    check("R8 stop seen", s_stops, 1);
    check("R8 lines released", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_addr_nack;
    wr(5'h0C, 8'h20); wr(5'h10, 8'h52); wait_clk(300);
    rdchk("R6 addr nack status", 5'h0C, 8'h21);
    check("R6 no hit", s_hits, 1);
    wr(5'h10, 8'h74); wait_clk(300);
    rdchk("R6 retry is address", 5'h0C, 8'hA2);
    check("R6 retry hit", s_hits, 2);
  endtask

  task automatic t_rstart;
    wr(5'h08, 8'hB4); rdchk("R11 bit self-clears", 5'h08, 8'hB0);
    wr(5'h0C, 8'h20); wr(5'h10, 8'h75); wait_clk(300);
    rdchk("R11 new address acked", 5'h0C, 8'hA2);
    check("R11 hit", s_hits, 3); check("R11 read flag", s_rw, 1);
    check("R11 no stop", s_stops, 1);
  endtask

  task automatic t_rx;
    wr(5'h08, 8'hA0); wr(5'h0C, 8'h20);
    rdchk("R9 read returns held", 5'h10, 8'h75);
    wait_clk(300);
    rdchk("R9 rx status", 5'h0C, 8'hA2);
    check("R9 master acked", s_mack, 1);
    wr(5'h08, 8'hA8);
    rdchk("R9 first byte", 5'h10, 8'hA5);
    wait_clk(300);
    check("R9 master nacked", s_mack, 0);
    wr(5'h08, 8'h80);
    rdchk("R3 busy cleared", 5'h0C, 8'h82);
    wait_clk(100);
    check("R3 stop seen", s_stops, 2);
    check("R3 lines released", {scl_oe, sda_oe}, 0);
    rdchk("R9 second byte no fetch", 5'h10, 8'hA6);
  endtask

  task automatic t_rx_fail;
    wr(5'h08, 8'hA0);
    rdchk("R10 returns held", 5'h10, 8'hA6);
    rdchk("R10 loads FF", 5'h10, 8'hFF);
    check("R10 no bus", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_soft;
    wr(5'h08, 8'h40);
    rdchk("R12 ctl", 5'h08, 8'h00); rdchk("R12 sta", 5'h0C, 8'h81);
    rdchk("R12 own kept", 5'h00, 8'hFE); rdchk("R12 div", 5'h04, 8'h00);
    rdchk("R12 dat", 5'h10, 8'h00); rdchk("R12 flt", 5'h14, 8'h00);
    check("R12 irq", irq, 0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    checks = 0; fails = 0; finished = 0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(2);
    t_reset(); t_masks(); t_disabled(); t_addr_ack(); t_tx(); t_irq();
    t_tx_nack(); t_addr_nack(); t_rstart(); t_rx(); t_rx_fail(); t_soft();
    summary();
  end
endmodule